// File: doc/BRIEF.md
# Codec Serial Port Frame Controller

This block is the slave-side serial port of a mono audio codec. All of its logic runs on the bit clock supplied by the host. A one-cycle frame-sync pulse marks the start of each slot. The port carries two kinds of traffic over the same three wires: 16-bit control words that program a bank of seven 10-bit registers, and audio sample words of 16, 20 or 24 bits. Each received audio word becomes a DAC sample with a one-cycle valid strobe. For each slot the port drives either an ADC sample or a status word back on the serial output.

After reset the port is in mixed mode. The first slot is a control slot, and after that control and audio slots alternate. A read request is answered in the status word of the following control slot, once the current sample interval has ended. Setting the data-mode bit turns every later slot into an audio slot. From then on no control word is decoded, and only a hardware reset brings the port back to mixed mode. The level on the serial input at the first bit clock after reset is latched as the slave/master strap.

Top module: `codec_sport`

## Requirements
- R1: After reset `sdout`, `reg_we`, `dac_valid` and `dac_data` are 0, and every writable register reads back 0. This gives mixed mode, 16-bit audio and a 128-clock frame.
- R2: `slave_mode` takes the value of `sdin` at the first rising bit clock after reset is released (1 = slave, 0 = master) and keeps it until the next reset.
- R3: A slot begins at the rising edge where `fsync` is high. The next W rising edges sample `sdin` MSB first. `sdout` shows the MSB of the outgoing word after the `fsync` edge and one lower bit after each following edge.
- R4: In mixed mode the first slot after reset is a control slot (W = 16), and later slots alternate audio, control, audio and so on.
- R5: In a control word, bit 15 = 1 means write, bits 14:11 are the address, bit 10 is ignored and bits 9:0 are the data. A write to address 0–5 gives a one-cycle `reg_we` pulse with `reg_addr`/`reg_wdata`. The pulse comes one clock after the edge that samples the last bit.
- R6: A write to address 6 (read-only, returns `ro_value`) or to address 7–15 produces no `reg_we`, and no register changes.
- R7: A control word with bit 15 = 0 is a read, and its data field is ignored. The next control slot returns the status word {1, address, 0, value}; address 6 yields `ro_value` and addresses 7–15 yield 0. In all other cases the status word is 0.
- R8: Mode register (address 2) bit 3 selects a 256-clock frame instead of a 128-clock frame. A read completes one frame length after its control slot's `fsync`. If the next control slot comes earlier, it returns status 0 and the read stays pending.
- R9: Mode register bits 2:1 set the audio length: 0 → 16, 1 → 20, 2 or 3 → 24 bits. The length applies to slots that start after the write.
- R10: After an audio slot, `dac_data` holds the received word left-justified: MSB at bit 23, unused low bits 0. `dac_valid` is high for exactly one cycle, one clock after the last bit's edge.
- R11: In an audio slot `sdout` sends the top W bits of `adc_data`, as captured at the `fsync` edge, MSB first.
- R12: `sdout` is 0 after the edge that samples a slot's last bit and stays 0 until the next `fsync`.
- R13: Writing 1 to mode register bit 0 makes every later slot an audio slot that uses the length in force at that moment. Control words are then neither decoded nor written, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the host; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| fsync | input | 1 | One-cycle slot-start pulse |
| sdin | input | 1 | Serial input (control words, DAC samples; strap after reset) |
| sdout | output | 1 | Serial output (status words, ADC samples) |
| slave_mode | output | 1 | Latched strap: 1 = slave, 0 = master |
| adc_data | input | 24 | ADC sample, MSB-aligned |
| ro_value | input | 10 | Value presented by the read-only register |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 4 | Address of the last register write |
| reg_wdata | output | 10 | Data of the last register write |
| dac_data | output | 24 | Last DAC sample, left-justified |
| dac_valid | output | 1 | One-cycle strobe for a new DAC sample |

## Verification
A wrong slot-kind bit or a miscounted bit counter shows up within the same slot. `dac_valid` or `reg_we` then appears in the wrong cycle or carries a shifted word, and `sdout` does not return to 0 one clock after the last bit. A stale or lost pending read only becomes visible at the next control slot, as a wrong status word, so every frame's status is compared against a bench model of the pending request. An incorrect frame length is shown by reads that complete too early or too late relative to a short frame. The sweep covers every word-length code, both frame lengths, read-only and out-of-range addresses, and the data-mode lock with its release by reset.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;

   // mode register field positions
   localparam int MODE_DATA_BIT = 0;
   localparam int MODE_WL_LSB   = 1;
   localparam int MODE_FAST_BIT = 3;

   typedef enum logic [1:0] {
      WL_16 = 2'd0,
      WL_20 = 2'd1,
      WL_24 = 2'd2,
      WL_24B = 2'd3
   } wl_code_e;

   function automatic int wl_bits(input logic [1:0] code);
      case (wl_code_e'(code))
         WL_16:   return 16;
         WL_20:   return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/sp_shifter.sv
module sp_shifter #(
   parameter int MAX_W = 24,
   parameter int CNT_W = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   input  logic [MAX_W-1:0] tx_word,
   input  logic             sdin,
   output logic             sdout,
   output logic             active,
   output logic             done,
   output logic [MAX_W-1:0] rx_word
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic [MAX_W-1:0] tx_q;
   logic             last;

   assign last = active && (cnt_q == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cnt_q   <= '0;
         len_q   <= '0;
         tx_q    <= '0;
         rx_word <= '0;
         sdout   <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active  <= 1'b1;
            cnt_q   <= '0;
            len_q   <= len;
            rx_word <= '0;
            sdout   <= tx_word[MAX_W-1];
            tx_q    <= tx_word << 1;
         end else if (active) begin
            rx_word <= {rx_word[MAX_W-2:0], sdin};
            cnt_q   <= cnt_q + 1'b1;
            if (last) begin
               active <= 1'b0;
               sdout  <= 1'b0;
               done   <= 1'b1;
            end else begin
               sdout <= tx_q[MAX_W-1];
               tx_q  <= tx_q << 1;
            end
         end
      end
   end
endmodule

// File: rtl/sp_framer.sv
module sp_framer #(
   parameter int NORM_FRAME = 128,
   parameter int FAST_FRAME = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic fast,
   output logic tick
);
   localparam int CW = $clog2(FAST_FRAME);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_pos;

   assign last_pos = fast ? CW'(FAST_FRAME - 1) : CW'(NORM_FRAME - 1);
   assign tick     = !restart && (cnt_q == last_pos - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart)           cnt_q <= '0;
      else if (cnt_q == last_pos) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sp_regbank.sv
module sp_regbank #(
   parameter int REG_W     = 10,
   parameter int ADDR_W    = 4,
   parameter int NUM_REGS  = 7,
   parameter int RO_ADDR   = 6,
   parameter int MODE_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [REG_W-1:0]  ro_value,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  mode_word
);
   logic [NUM_REGS*REG_W-1:0] flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == RO_ADDR) begin : g_ro
         assign flat[i*REG_W +: REG_W] = ro_value;
      end else begin : g_rw
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (we && (waddr == ADDR_W'(i)))    q <= wdata;
         end
         assign flat[i*REG_W +: REG_W] = q;
      end
   end

   assign rdata     = (int'(raddr) < NUM_REGS) ? flat[int'(raddr)*REG_W +: REG_W] : '0;
   assign mode_word = flat[MODE_ADDR*REG_W +: REG_W];
endmodule

// File: rtl/codec_sport.sv
module codec_sport
   import codec_sp_pkg::*;
#(
   parameter int MAX_W      = 24,
   parameter int REG_W      = 10,
   parameter int ADDR_W     = 4,
   parameter int NUM_REGS   = 7,
   parameter int RO_ADDR    = 6,
   parameter int MODE_ADDR  = 2,
   parameter int NORM_FRAME = 128,
   parameter int FAST_FRAME = 256
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              sdin,
   output logic              sdout,
   output logic              slave_mode,
   input  logic [MAX_W-1:0]  adc_data,
   input  logic [REG_W-1:0]  ro_value,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [REG_W-1:0]  reg_wdata,
   output logic [MAX_W-1:0]  dac_data,
   output logic              dac_valid
);
   localparam int CTRL_W = 1 + ADDR_W + 1 + REG_W;
   localparam int CNT_W  = $clog2(MAX_W + 1);

   if (CTRL_W > MAX_W) begin : g_chk_width
      $error("control word wider than the longest slot");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_chk_regs
      $error("register count exceeds address space");
   end
   if (RO_ADDR >= NUM_REGS || MODE_ADDR >= NUM_REGS || RO_ADDR == MODE_ADDR) begin : g_chk_addr
      $error("read-only or mode address invalid");
   end
   if (FAST_FRAME <= NORM_FRAME || NORM_FRAME < 2 * MAX_W + 2) begin : g_chk_frame
      $error("frame lengths inconsistent");
   end
   if (REG_W <= MODE_FAST_BIT) begin : g_chk_mode
      $error("register too narrow for mode fields");
   end

   // strap capture
   logic strap_done_q;
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         strap_done_q <= 1'b0;
         slave_mode   <= 1'b0;
      end else if (!strap_done_q) begin
         strap_done_q <= 1'b1;
         slave_mode   <= sdin;
      end
   end

   // mode fields
   logic [REG_W-1:0]  mode_word;
   logic [REG_W-1:0]  rdata;
   logic              data_mode;
   logic              fast_frame;
   logic [CNT_W-1:0]  audio_len;

   assign data_mode  = mode_word[MODE_DATA_BIT];
   assign fast_frame = mode_word[MODE_FAST_BIT];
   assign audio_len  = CNT_W'(wl_bits(mode_word[MODE_WL_LSB +: 2]));

   // slot sequencing
   logic             next_ctrl_q;
   logic             ctrl_slot_q;
   logic [CNT_W-1:0] slot_len_q;
   logic             start_ctrl;
   logic [CNT_W-1:0] start_len;
   logic [CTRL_W-1:0] status_q;
   logic [MAX_W-1:0] tx_word;

   assign start_ctrl = fsync && !data_mode && next_ctrl_q;
   assign start_len  = start_ctrl ? CNT_W'(CTRL_W) : audio_len;
   assign tx_word    = start_ctrl ? {status_q, {(MAX_W-CTRL_W){1'b0}}} : adc_data;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         next_ctrl_q <= 1'b1;
         ctrl_slot_q <= 1'b0;
         slot_len_q  <= CNT_W'(CTRL_W);
      end else if (fsync) begin
         ctrl_slot_q <= start_ctrl;
         slot_len_q  <= start_len;
         if (!data_mode) next_ctrl_q <= !next_ctrl_q;
      end
   end

   logic             shift_active;
   logic             shift_done;
   logic [MAX_W-1:0] rx_word;

   sp_shifter #(.MAX_W(MAX_W), .CNT_W(CNT_W)) i_shifter (
      .clk     (bclk),
      .rst_n   (rst_n),
      .start   (fsync),
      .len     (start_len),
      .tx_word (tx_word),
      .sdin    (sdin),
      .sdout   (sdout),
      .active  (shift_active),
      .done    (shift_done),
      .rx_word (rx_word)
   );

   // control word decode
   logic              ctrl_done;
   logic              cw_write;
   logic [ADDR_W-1:0] cw_addr;
   logic [REG_W-1:0]  cw_data;
   logic              addr_ok;
   logic              wr_en;
   logic              rd_req;

   assign ctrl_done = shift_done && ctrl_slot_q;
   assign cw_write  = rx_word[CTRL_W-1];
   assign cw_addr   = rx_word[CTRL_W-2 -: ADDR_W];
   assign cw_data   = rx_word[REG_W-1:0];
   assign addr_ok   = (int'(cw_addr) < NUM_REGS) && (int'(cw_addr) != RO_ADDR);
   assign wr_en     = ctrl_done && cw_write && addr_ok;
   assign rd_req    = ctrl_done && !cw_write;

   // read scheduling
   logic              tick;
   logic              pend_q;
   logic [ADDR_W-1:0] pend_addr_q;

   sp_framer #(.NORM_FRAME(NORM_FRAME), .FAST_FRAME(FAST_FRAME)) i_framer (
      .clk     (bclk),
      .rst_n   (rst_n),
      .restart (start_ctrl),
      .fast    (fast_frame),
      .tick    (tick)
   );

   sp_regbank #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
      .RO_ADDR(RO_ADDR), .MODE_ADDR(MODE_ADDR)
   ) i_regbank (
      .clk       (bclk),
      .rst_n     (rst_n),
      .we        (wr_en),
      .waddr     (cw_addr),
      .wdata     (cw_data),
      .raddr     (pend_addr_q),
      .ro_value  (ro_value),
      .rdata     (rdata),
      .mode_word (mode_word)
   );

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
         status_q    <= '0;
      end else begin
         if (rd_req) begin
            pend_q      <= 1'b1;
            pend_addr_q <= cw_addr;
         end else if (tick && pend_q) begin
            pend_q <= 1'b0;
         end
         if (tick && pend_q && !rd_req)
            status_q <= {1'b1, pend_addr_q, 1'b0, rdata};
         else if (start_ctrl)
            status_q <= '0;
      end
   end

   // outputs
   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         dac_data  <= '0;
         dac_valid <= 1'b0;
      end else begin
         reg_we    <= wr_en;
         dac_valid <= shift_done && !ctrl_slot_q;
         if (wr_en) begin
            reg_addr  <= cw_addr;
            reg_wdata <= cw_data;
         end
         if (shift_done && !ctrl_slot_q)
            dac_data <= rx_word << (CNT_W'(MAX_W) - slot_len_q);
      end
   end
endmodule

// File: rtl/codec_sport_chk.sv
module codec_sport_chk #(
   parameter int ADDR_W   = 4,
   parameter int NUM_REGS = 7,
   parameter int RO_ADDR  = 6
) (
   input logic              bclk,
   input logic              rst_n,
   input logic              sdout,
   input logic              shift_active,
   input logic              dac_valid,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              data_mode,
   input logic              strap_done,
   input logic              slave_mode
);
   assert_strap_hold_R2: assert property (@(posedge bclk) disable iff (!rst_n)
      strap_done |=> $stable(slave_mode));

   assert_slot_kind_excl_R4: assert property (@(posedge bclk) disable iff (!rst_n)
      !(reg_we && dac_valid));

   assert_we_pulse_R5: assert property (@(posedge bclk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_no_ro_write_R6: assert property (@(posedge bclk) disable iff (!rst_n)
      reg_we |-> ((int'(reg_addr) < NUM_REGS) && (int'(reg_addr) != RO_ADDR)));

   assert_valid_pulse_R10: assert property (@(posedge bclk) disable iff (!rst_n)
      dac_valid |=> !dac_valid);

   assert_idle_low_R12: assert property (@(posedge bclk) disable iff (!rst_n)
      !shift_active |-> !sdout);

   assert_dmode_sticky_R13: assert property (@(posedge bclk) disable iff (!rst_n)
      data_mode |=> data_mode);

   assert_dmode_no_we_R13: assert property (@(posedge bclk) disable iff (!rst_n)
      data_mode |=> !reg_we);
endmodule

bind codec_sport codec_sport_chk #(
   .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RO_ADDR(RO_ADDR)
) i_codec_sport_chk (
   .bclk         (bclk),
   .rst_n        (rst_n),
   .sdout        (sdout),
   .shift_active (shift_active),
   .dac_valid    (dac_valid),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .data_mode    (data_mode),
   .strap_done   (strap_done_q),
   .slave_mode   (slave_mode)
);

// File: tb/test_codec_sport.sv
module test_codec_sport;
   timeunit 1ns;
   timeprecision 1ps;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic        sdin = 1'b0;
   logic        sdout;
   logic        slave_mode;
   logic [23:0] adc_data = '0;
   logic [9:0]  ro_value = 10'h1C7;
   logic        reg_we;
   logic [3:0]  reg_addr;
   logic [9:0]  reg_wdata;
   logic [23:0] dac_data;
   logic        dac_valid;

   always #4 bclk = ~bclk;

   codec_sport i_codec_sport (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin), .sdout(sdout),
      .slave_mode(slave_mode), .adc_data(adc_data), .ro_value(ro_value),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .dac_data(dac_data), .dac_valid(dac_valid)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench model
   logic [9:0]  m_regs [7];
   logic        m_pend;
   logic [3:0]  m_paddr;
   logic [15:0] m_rb;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int wl(input logic [1:0] c);
      return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
   endfunction

   function automatic logic [23:0] msk(input int w);
      return 24'hFFFFFF << (24 - w);
   endfunction

   function automatic logic [9:0] rdval(input logic [3:0] a);
      if (a == 4'd6) return ro_value;
      if (a < 4'd7) return m_regs[a];
      return '0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 7; i++) m_regs[i] = '0;
      m_pend = 0; m_paddr = '0; m_rb = '0;
   endtask

   task automatic do_reset(input logic strap);
      sdin = strap; fsync = 0; rst_n = 0;
      repeat (3) @(negedge bclk);
      rst_n = 1;
      @(negedge bclk);
      sdin = 0;
      model_reset();
      chk(slave_mode == strap, "R2 strap", 32'(slave_mode), 32'(strap));
      chk(sdout == 0 && reg_we == 0 && dac_valid == 0 && dac_data == 0, "R1 reset state",
          {sdout, reg_we, dac_valid, dac_data != 0}, 0);
   endtask

   task automatic run_slot(input logic [23:0] word, input int w,
                           output logic [23:0] tx, output logic v, output logic [23:0] dd,
                           output logic we, output logic [3:0] wa, output logic [9:0] wd,
                           output logic idl, output logic gone);
      fsync = 1;
      @(negedge bclk);
      fsync = 0;
      tx = '0;
      for (int j = 0; j < w; j++) begin
         tx[23-j] = sdout;
         sdin = word[23-j];
         @(negedge bclk);
      end
      idl = (sdout == 1'b0);
      sdin = 0;
      @(negedge bclk);
      v = dac_valid; dd = dac_data; we = reg_we; wa = reg_addr; wd = reg_wdata;
      @(negedge bclk);
      gone = !dac_valid && !reg_we;
   endtask

   task automatic frame(input logic [15:0] cw, input logic [23:0] aw, input int period);
      logic [23:0] tx; logic v; logic [23:0] dd; logic we; logic [3:0] wa; logic [9:0] wd;
      logic idl, gone, exp_we;
      logic [15:0] exp_st;
      logic [23:0] adc_exp;
      int w;
      exp_st = m_rb; m_rb = '0;
      run_slot({cw, 8'h00}, 16, tx, v, dd, we, wa, wd, idl, gone);
      chk(tx[23:8] == exp_st, "R7 status word", 32'(tx[23:8]), 32'(exp_st));
      exp_we = 0;
      if (cw[15]) begin
         if (cw[14:11] < 4'd7 && cw[14:11] != 4'd6) begin
            exp_we = 1;
            m_regs[cw[14:11]] = cw[9:0];
         end
      end else begin
         m_pend = 1; m_paddr = cw[14:11];
      end
      chk(we == exp_we && v == 0, exp_we ? "R5 write strobe" : "R6 no write strobe", 32'(we), 32'(exp_we));
      if (exp_we)
         chk(wa == cw[14:11] && wd == cw[9:0], "R5 write addr/data", {wa, wd}, {cw[14:11], cw[9:0]});
      chk(idl && gone, "R12 idle after control slot", {idl, gone}, 2'b11);
      repeat (32 - 19) @(negedge bclk);
      w = wl(m_regs[2][2:1]);
      adc_data = {aw[11:0], aw[23:12]} ^ 24'h96C3A5;
      adc_exp = adc_data & msk(w);
      run_slot(aw, w, tx, v, dd, we, wa, wd, idl, gone);
      chk(v == 1 && we == 0, "R4 audio slot strobe", {v, we}, 2'b10);
      chk(dd == (aw & msk(w)), "R10 R9 dac sample", dd, aw & msk(w));
      chk(tx == adc_exp, "R11 R3 adc bits", tx, adc_exp);
      chk(idl && gone, "R12 R10 idle and single pulse", {idl, gone}, 2'b11);
      repeat (period - 32 - (w + 3)) @(negedge bclk);
      if (m_pend && period >= (m_regs[2][3] ? 256 : 128)) begin
         m_rb = {1'b1, m_paddr, 1'b0, rdval(m_paddr)};
         m_pend = 0;
      end
   endtask

   task automatic dslot(input logic [23:0] aw, input int w);
      logic [23:0] tx; logic v; logic [23:0] dd; logic we; logic [3:0] wa; logic [9:0] wd;
      logic idl, gone;
      logic [23:0] adc_exp;
      adc_data = ~aw;
      adc_exp = adc_data & msk(w);
      run_slot(aw, w, tx, v, dd, we, wa, wd, idl, gone);
      chk(v == 1 && we == 0, "R13 data-mode slot is audio", {v, we}, 2'b10);
      chk(dd == (aw & msk(w)), "R13 data-mode sample", dd, aw & msk(w));
      chk(tx == adc_exp, "R11 data-mode adc", tx, adc_exp);
      chk(idl && gone, "R12 data-mode idle", {idl, gone}, 2'b11);
      repeat (5) @(negedge bclk);
   endtask

   initial begin
      do_reset(1'b0);
      do_reset(1'b1);

      frame(16'h1000, 24'hA5C3F0, 128);   // read mode reg
      frame(16'h86AA, 24'h3C1E77, 128);   // write reg0, reserved bit set
      frame(16'h03FF, 24'h800001, 128);   // read reg0, data field junk
      frame(16'hB155, 24'h7FFFFE, 128);   // write read-only reg (R6)
      frame(16'h3000, 24'h123456, 128);   // read ro reg
      frame(16'hC8FF, 24'hFEDCBA, 128);   // write addr 9 (R6)
      frame(16'h0800, 24'h0F0F0F, 128);   // read reg1: no alias
      frame(16'hFFFF, 24'hF0F0F0, 128);   // write addr 15 (R6)

      for (int c = 0; c < 4; c++) begin    // R9 sweep
         frame(16'h9000 | 16'(c << 1), 24'hC0FFEE ^ 24'(c * 24'h111111), 128);
         frame(16'h1000, 24'h5AA55A ^ 24'(c * 24'h0A0B0C), 128);
         frame(16'h0000, 24'hFFFFFF >> c, 128);
      end

      frame(16'h9008, 24'h13579B, 256);   // fast frame (R8)
      frame(16'h1000, 24'h2468AC, 256);
      frame(16'h1000, 24'hABCDEF, 128);   // short frame: read stays pending
      frame(16'h0000, 24'h112233, 256);   // R8 expects status 0 here
      frame(16'h9923, 24'h445566, 256);
      frame(16'h9000, 24'h778899, 128);
      frame(16'h1800, 24'h99AABB, 128);

      frame(16'h9001, 24'hCAFE00, 128);   // enter data mode (R13)
      dslot(24'h9004AB, 16);               // looks like a mode write
      dslot(24'h86AA00, 16);               // still 16 bits
      dslot(24'h000100, 16);
      dslot(24'hFFFF00, 16);

      do_reset(1'b1);                      // R13 release by reset
      frame(16'h1000, 24'h010203, 128);
      frame(16'h0000, 24'h040506, 128);
      frame(16'h0000, 24'h070809, 128);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule